// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Flags

This block keeps the status that sits beside a UART's transmit and receive FIFOs. It follows each FIFO's fill level from the push and pop strobes the FIFO sees. From those levels it derives two empty indicators and three sticky error flags: receive overflow, transmit overflow and receive underflow. The block does not use the shift registers, so a character that is still being serialised or assembled has no effect on the empty indicators.

Software reads all five indicators as one 8-bit status byte. It clears an error flag by writing 1 to that flag's bit; writing 0 leaves the flag as it is. The enable bits come from a separate control register. A single host interrupt is raised whenever a set error flag has its enable bit on. The flag itself latches whether or not its enable is on.

Top module: `uart_fifo_status`

## Requirements
- R1: After a synchronous reset the status byte reads 0xC0 and `irq` is 0.
- R2: Bit 7 reads 1 exactly when the transmit level is zero. The level rises on an accepted push, falls on a pop from a non-empty FIFO, and never exceeds `TX_DEPTH`. A push while full without a same-cycle pop is dropped.
- R3: Bit 6 reads 1 exactly when the receive level is zero. The receive level follows the same push and pop rules as R2, with the bound `RX_DEPTH`.
- R4: Bits 5 to 3 always read 0. Writing 1s to them changes nothing.
- R5: Bit 2 (receive overflow) sets in the cycle after an `rx_push` while the receive FIFO is full and `rx_pop` is low. This happens whatever `ien_rxof` holds.
- R6: Bit 1 (transmit overflow) sets in the cycle after a `tx_push` while the transmit FIFO is full and `tx_pop` is low.
- R7: Bit 0 (receive underflow) sets in the cycle after an `rx_pop` while the receive FIFO is empty.
- R8: A write with a 1 in bit 2, 1 or 0 clears that flag. A 0 in that position leaves the flag unchanged. A flag with no event and no clear holds its value.
- R9: If a flag's set event and its write-1 clear fall in the same cycle, the flag ends up set.
- R10: `irq` equals (bit2 & `ien_rxof`) | (bit1 & `ien_txof`) | (bit0 & `ien_rxuf`) at all times.
- R11: A `tx_pop` while the transmit FIFO is empty sets no flag and leaves the level at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| tx_pop | input | 1 | Read strobe out of the transmit FIFO |
| rx_push | input | 1 | Write strobe into the receive FIFO |
| rx_pop | input | 1 | Read strobe out of the receive FIFO |
| ien_rxof | input | 1 | Interrupt enable for receive overflow |
| ien_txof | input | 1 | Interrupt enable for transmit overflow |
| ien_rxuf | input | 1 | Interrupt enable for receive underflow |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Write data; 1s in bits 2..0 clear flags |
| reg_rdata | output | 8 | Status byte |
| irq | output | 1 | Host interrupt request |

## Verification
The bench builds the block with `TX_DEPTH` = 4 and `RX_DEPTH` = 3. Because the two depths differ, a swapped bound or a swapped pair of strobes shows up at once. Both depths are shallow, so a few thousand strobe cycles repeatedly walk each FIFO through empty, full, overflow and underflow.

A pseudo-random sweep with push-heavy, pop-heavy and balanced phases crosses every strobe combination with random clear writes and enable patterns. Directed steps then pin down the same-cycle set-versus-clear case and the pop from an empty transmit FIFO.

// File: rtl/uart_fifo_status_pkg.sv
package uart_fifo_status_pkg;
  localparam int unsigned BIT_TX_EMPTY = 7;
  localparam int unsigned BIT_RX_EMPTY = 6;
  localparam int unsigned BIT_RX_OVF   = 2;
  localparam int unsigned BIT_TX_OVF   = 1;
  localparam int unsigned BIT_RX_UDF   = 0;
  localparam int unsigned NUM_ERR      = 3;
endpackage

// File: rtl/uart_fifo_level.sv
module uart_fifo_level #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  output logic empty,
  output logic full
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic          accept;
  logic          take;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign accept = push && (!full || pop);
  assign take   = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(accept) - CW'(take);
  end

  // R2: the level never goes past the depth
  p_bound_r2: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
  // R2: a push into a full FIFO with no pop leaves the level alone
  p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (cnt == $past(cnt)));
  // R2: draining the last entry reports empty
  p_drain_empty_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1) && pop && !push) |=> empty);
endmodule

// File: rtl/uart_err_flag.sv
module uart_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst) set |=> q);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst) (clr && !set) |=> !q);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set) |=> (q == $past(q)));
endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
  import uart_fifo_status_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_push,
  input  logic       tx_pop,
  input  logic       rx_push,
  input  logic       rx_pop,
  input  logic       ien_rxof,
  input  logic       ien_txof,
  input  logic       ien_rxuf,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [NUM_ERR-1:0] err_evt, err_clr, err_q, err_en;

  uart_fifo_level #(.DEPTH(TX_DEPTH)) u_tx_level (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop),
    .empty(tx_empty), .full(tx_full));

  uart_fifo_level #(.DEPTH(RX_DEPTH)) u_rx_level (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop),
    .empty(rx_empty), .full(rx_full));

  always_comb begin
    err_evt             = '0;
    err_evt[BIT_RX_OVF] = rx_push && rx_full && !rx_pop;
    err_evt[BIT_TX_OVF] = tx_push && tx_full && !tx_pop;
    err_evt[BIT_RX_UDF] = rx_pop && rx_empty;
    err_en              = '0;
    err_en[BIT_RX_OVF]  = ien_rxof;
    err_en[BIT_TX_OVF]  = ien_txof;
    err_en[BIT_RX_UDF]  = ien_rxuf;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
    assign err_clr[g] = reg_wr && reg_wdata[g];
    uart_err_flag u_flag (
      .clk(clk), .rst(rst), .set(err_evt[g]), .clr(err_clr[g]), .q(err_q[g]));
  end

  assign reg_rdata = {tx_empty, rx_empty, 3'b000, err_q};
  assign irq       = |(err_q & err_en);

  p_rxof_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !rx_pop) |=> reg_rdata[BIT_RX_OVF]);
  p_txof_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_full && !tx_pop) |=> reg_rdata[BIT_TX_OVF]);
  p_rxuf_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> reg_rdata[BIT_RX_UDF]);
  p_txpop_empty_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_empty && !tx_push) |=> reg_rdata[BIT_TX_EMPTY]);
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!ien_rxof && !ien_txof && !ien_rxuf) |-> !irq);
endmodule

// File: tb/uart_fifo_status_tb.sv
module uart_fifo_status_tb;
  localparam int TXD = 4;
  localparam int RXD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic ien_rxof = 0, ien_txof = 0, ien_rxuf = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq;

  always #10 clk = ~clk;

  uart_fifo_status #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
    .clk(clk), .rst(rst), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_pop(rx_pop), .ien_rxof(ien_rxof),
    .ien_txof(ien_txof), .ien_rxuf(ien_rxuf), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  int n_chk = 0, n_fail = 0;
  int m_tx = 0, m_rx = 0;
  logic [2:0] m_flg = 3'b000;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    check("R2 tx empty", int'(reg_rdata[7]), int'(m_tx == 0));
    check("R3 rx empty", int'(reg_rdata[6]), int'(m_rx == 0));
    check("R4 reserved", int'(reg_rdata[5:3]), 0);
    check("R5 rx overflow", int'(reg_rdata[2]), int'(m_flg[2]));
    check("R6 tx overflow", int'(reg_rdata[1]), int'(m_flg[1]));
    check("R7 R8 R9 rx underflow", int'(reg_rdata[0]), int'(m_flg[0]));
    check("R10 irq", int'(irq),
          int'((m_flg[2] & ien_rxof) | (m_flg[1] & ien_txof) | (m_flg[0] & ien_rxuf)));
  endtask

  task automatic step(bit tp, bit to, bit rp, bit ro, bit w, logic [7:0] d, logic [2:0] en);
    logic [2:0] evt;
    tx_push = tp; tx_pop = to; rx_push = rp; rx_pop = ro;
    reg_wr = w; reg_wdata = d;
    {ien_rxof, ien_txof, ien_rxuf} = en;
    evt[2] = rp && (m_rx == RXD) && !ro;
    evt[1] = tp && (m_tx == TXD) && !to;
    evt[0] = ro && (m_rx == 0);
    m_flg = (m_flg & ~(w ? d[2:0] : 3'b000)) | evt;
    m_tx = m_tx + int'(tp && (m_tx < TXD || to)) - int'(to && m_tx > 0);
    m_rx = m_rx + int'(rp && (m_rx < RXD || ro)) - int'(ro && m_rx > 0);
    @(posedge clk); #1;
    check_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    bit tp, to, rp, ro;
    lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset status", int'(reg_rdata), 8'hC0);
    check("R1 reset irq", int'(irq), 0);
    rst = 0;
    @(posedge clk); #1;
    check("R1 after release", int'(reg_rdata), 8'hC0);

    // R4: write ones everywhere, reserved must stay zero and empties unchanged
    step(0, 0, 0, 0, 1, 8'hFF, 3'b111);

    // R11: pop from empty transmit FIFO
    step(0, 1, 0, 0, 0, 8'h00, 3'b111);
    check("R11 no tx flag", int'(reg_rdata[2:0]), 0);

    // R6: fill transmit FIFO and overflow with enable off
    for (int i = 0; i < TXD; i++) step(1, 0, 0, 0, 0, 8'h00, 3'b000);
    step(1, 0, 0, 0, 0, 8'h00, 3'b000);
    check("R6 latched, enable off", int'(reg_rdata[1]), 1);
    check("R10 irq off while disabled", int'(irq), 0);
    step(0, 0, 0, 0, 0, 8'h00, 3'b010);
    check("R10 irq on with enable", int'(irq), 1);
    // R8: write 0 keeps, write 1 clears
    step(0, 0, 0, 0, 1, 8'hFD, 3'b010);
    check("R8 zero write keeps", int'(reg_rdata[1]), 1);
    step(0, 0, 0, 0, 1, 8'h02, 3'b010);
    check("R8 one write clears", int'(reg_rdata[1]), 0);

    // R9: overflow again and clear in the same cycle
    step(1, 0, 0, 0, 1, 8'h02, 3'b000);
    check("R9 set wins", int'(reg_rdata[1]), 1);
    // R7 and R9 on receive underflow
    step(0, 0, 0, 1, 1, 8'h01, 3'b001);
    check("R9 underflow set wins", int'(reg_rdata[0]), 1);
    // R5: fill receive FIFO and overflow
    for (int i = 0; i <= RXD; i++) step(0, 0, 1, 0, 0, 8'h00, 3'b000);
    check("R5 rx overflow latched", int'(reg_rdata[2]), 1);
    step(0, 0, 0, 0, 1, 8'h07, 3'b000);

    // sweep: push-heavy, pop-heavy, balanced phases
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ph)
          0: begin tp = lfsr[0] | lfsr[1]; to = lfsr[2] & lfsr[3];
                   rp = lfsr[4] | lfsr[5]; ro = lfsr[6] & lfsr[7]; end
          1: begin tp = lfsr[0] & lfsr[1]; to = lfsr[2] | lfsr[3];
                   rp = lfsr[4] & lfsr[5]; ro = lfsr[6] | lfsr[7]; end
          default: begin tp = lfsr[0]; to = lfsr[3]; rp = lfsr[5]; ro = lfsr[7]; end
        endcase
        step(tp, to, rp, ro, lfsr[8] & lfsr[9], {lfsr[15:11], lfsr[10:8]},
             lfsr[14:12]);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule